// File: doc/BRIEF.md
# Password-Gated Serial Command Front End

This block is the slave-side protocol engine of a two-wire serial memory. It watches the clock and data lines while an active-low chip select is asserted. A start condition opens a transaction. A command byte then picks one of four stored 64-bit passwords and the access direction. Eight password bytes follow, and the block compares each one against the chosen stored password as it arrives. The block acknowledges every accepted byte by pulling the data line low during the ninth clock.

After the password, the master polls with a new start and any byte. The poll is acknowledged only when all eight bytes matched and no nonvolatile write is in progress. An acknowledged poll raises a one-cycle grant and holds an open level toward the downstream array controller. A mismatch raises a one-cycle deny, and the block drops back to standby. A busy flag during the command byte, a stop condition or a deselect also returns the block to standby.

The password store sits inside the block. It clears to all zeros on reset and can be overwritten one entry at a time through a load port.

Top module: `pwf_front`

## Requirements
- R1: After reset all four stored passwords are zero, the block is in standby, `sda_oe_o` is low, `open_o` is low, and neither `grant_o` nor `deny_o` pulses.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Both count only while `cs_n_i` is low. The first byte after a start in standby is the command. Command bit 7 selects write (1) or read (0), bits 1:0 give the password index, and bits 6:2 are ignored.
- R3: Bytes arrive most significant bit first on SCL rising edges. For each accepted byte, `sda_oe_o` rises after the eighth SCL falling edge and is released after the ninth SCL falling edge.
- R4: The eight password bytes are compared with the stored password chosen by the command. The first byte sent matches bits 63:56 and the last byte matches bits 7:0.
- R5: All eight password bytes are acknowledged whether they match or not. After a mismatch the poll byte is not acknowledged, `deny_o` pulses for one cycle, and the block returns to standby.
- R6: After the eighth password byte, a start followed by any poll byte is acknowledged when the password matched and `wr_busy_i` is low. The block then pulses `grant_o` for one cycle, raises `open_o`, and presents the command's index on `sel_o` and its direction on `dir_wr_o`. `grant_o` and `deny_o` never pulse together.
- R7: A command byte received while `wr_busy_i` is high is not acknowledged, and the block returns to standby. Later bytes without a new start are not acknowledged.
- R8: A poll received while `wr_busy_i` is high is not acknowledged, and the block keeps waiting for a poll. A later poll with `wr_busy_i` low can be granted.
- R9: A stop in any state returns the block to standby and lowers `open_o`. Password progress made before the stop is dropped, so no grant follows from it.
- R10: While `cs_n_i` is high the block is in standby, `open_o` is low, and starts and bytes are ignored: no acknowledge is driven.
- R11: A cycle with `pw_load_i` high replaces the stored password at `pw_load_idx_i` with `pw_load_val_i`. The new value is used by the next comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Active-low chip select |
| scl_i | input | 1 | Serial clock, synchronised to `clk` |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_o | output | 1 | Value driven on SDA when enabled (always 0) |
| sda_oe_o | output | 1 | SDA output enable, high to pull the line low for an acknowledge |
| wr_busy_i | input | 1 | Nonvolatile write in progress |
| pw_load_i | input | 1 | Write strobe for the password store |
| pw_load_idx_i | input | 2 | Password entry to overwrite |
| pw_load_val_i | input | 64 | New password value |
| sel_o | output | 2 | Password index taken from the command |
| dir_wr_o | output | 1 | Direction taken from the command, 1 = write |
| grant_o | output | 1 | One-cycle pulse: access granted |
| deny_o | output | 1 | One-cycle pulse: access refused after a mismatch |
| open_o | output | 1 | Data transfer window is open |

## Verification
The comparison is exercised with several password patterns. The all-zero value on a fresh store shows the reset contents. A loaded value confirms the load port and the index selection, and the same value offered to another index must be denied. A corrupted final byte shows that the mismatch is reported only at the poll. A byte-reversed copy of the loaded value exposes any reversal of byte order. Command bytes with the ignored bits set check the decode, and the busy flag is applied once at the command and once at the poll to separate the nack-to-standby path from the nack-and-wait path. Stops in the middle of the password and deselects while open check that earlier progress is dropped.

// File: rtl/pwf_pkg.sv
package pwf_pkg;

    localparam int PW_NUM     = 4;
    localparam int PW_BYTES   = 8;
    localparam int BYTE_W     = 8;
    localparam int PW_W       = PW_NUM > 0 ? PW_BYTES * BYTE_W : 0;
    localparam int IDX_W      = $clog2(PW_NUM);
    localparam int CNT_W      = $clog2(PW_BYTES);
    localparam int CMD_WR_BIT = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_PW,
        ST_POLL,
        ST_OPEN
    } st_e;

    typedef struct packed {
        logic             wr;
        logic [IDX_W-1:0] idx;
    } cmd_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    function automatic logic rx_state(input st_e s);
        return (s == ST_CMD) || (s == ST_PW) || (s == ST_POLL);
    endfunction

endpackage

// File: rtl/pwf_bus_cond.sv
module pwf_bus_cond
    import pwf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_n,
    input  logic    scl,
    input  logic    sda,
    output bus_ev_t ev
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    always_comb begin
        ev.start = ~cs_n & scl & scl_q & sda_q & ~sda;
        ev.stop  = ~cs_n & scl & scl_q & ~sda_q & sda;
        ev.rise  = ~cs_n & scl & ~scl_q;
        ev.fall  = ~cs_n & ~scl & scl_q;
    end

endmodule

// File: rtl/pwf_byte_rx.sv
module pwf_byte_rx
    import pwf_pkg::*;
#(
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    input  bus_ev_t       ev,
    input  logic          sda,
    input  logic          ack_en,
    output logic          byte_done,
    output logic [BW-1:0] byte_val,
    output logic          ack_drv
);

    localparam int CW = $clog2(BW + 2);
    localparam logic [CW-1:0] LAST = CW'(BW);
    localparam logic [CW-1:0] SLOT = CW'(BW + 1);

    logic [CW-1:0] cnt;
    logic [BW-1:0] sh;

    assign byte_done = en & ev.fall & (cnt == LAST);
    assign byte_val  = sh;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt     <= '0;
            sh      <= '0;
            ack_drv <= 1'b0;
        end else if (ev.start) begin
            cnt     <= '0;
            ack_drv <= 1'b0;
        end else if (ev.rise && en && cnt < LAST) begin
            sh  <= {sh[BW-2:0], sda};
            cnt <= cnt + 1'b1;
        end else if (ev.fall && cnt == LAST) begin
            cnt     <= SLOT;
            ack_drv <= byte_done & ack_en;
        end else if (ev.fall && cnt == SLOT) begin
            cnt     <= '0;
            ack_drv <= 1'b0;
        end
    end

endmodule

// File: rtl/pwf_pw_bank.sv
module pwf_pw_bank
    import pwf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [IDX_W-1:0]  load_idx,
    input  logic [PW_W-1:0]   load_val,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [CNT_W-1:0]  rd_byte,
    output logic [BYTE_W-1:0] rd_val
);

    logic [PW_W-1:0] words [PW_NUM];
    logic [PW_W-1:0] sel_word;
    logic [PW_W-1:0] shifted;

    for (genvar g = 0; g < PW_NUM; g++) begin : g_ent
        logic [PW_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (load && load_idx == IDX_W'(g)) begin
                word_q <= load_val;
            end
        end
        assign words[g] = word_q;
    end

    assign sel_word = words[rd_idx];
    assign shifted  = sel_word >> (BYTE_W * (PW_BYTES - 1 - int'(rd_byte)));
    assign rd_val   = shifted[BYTE_W-1:0];

endmodule

// File: rtl/pwf_front.sv
module pwf_front
    import pwf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n_i,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_o,
    output logic             sda_oe_o,
    input  logic             wr_busy_i,
    input  logic             pw_load_i,
    input  logic [IDX_W-1:0] pw_load_idx_i,
    input  logic [PW_W-1:0]  pw_load_val_i,
    output logic [IDX_W-1:0] sel_o,
    output logic             dir_wr_o,
    output logic             grant_o,
    output logic             deny_o,
    output logic             open_o
);

    localparam logic [CNT_W-1:0] PW_LAST = CNT_W'(PW_BYTES - 1);

    bus_ev_t           ev;
    st_e               st;
    cmd_t              cmd_q;
    logic [CNT_W-1:0]  pw_cnt;
    logic              match_q;
    logic              grant_q;
    logic              deny_q;
    logic              ack_en;
    logic              byte_done;
    logic [BYTE_W-1:0] byte_val;
    logic              ack_drv;
    logic [BYTE_W-1:0] pw_byte;
    logic              stop_det;
    logic              rx_clr;

    assign stop_det = ev.stop;
    assign rx_clr   = cs_n_i | ev.stop;

    pwf_bus_cond u_cond (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n_i),
        .scl  (scl_i),
        .sda  (sda_i),
        .ev   (ev)
    );

    pwf_byte_rx #(.BW(BYTE_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .clr       (rx_clr),
        .en        (rx_state(st)),
        .ev        (ev),
        .sda       (sda_i),
        .ack_en    (ack_en),
        .byte_done (byte_done),
        .byte_val  (byte_val),
        .ack_drv   (ack_drv)
    );

    pwf_pw_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .load     (pw_load_i),
        .load_idx (pw_load_idx_i),
        .load_val (pw_load_val_i),
        .rd_idx   (cmd_q.idx),
        .rd_byte  (pw_cnt),
        .rd_val   (pw_byte)
    );

    always_comb begin
        case (st)
            ST_CMD:  ack_en = ~wr_busy_i;
            ST_PW:   ack_en = 1'b1;
            ST_POLL: ack_en = match_q & ~wr_busy_i;
            default: ack_en = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cmd_q   <= '0;
            pw_cnt  <= '0;
            match_q <= 1'b0;
            grant_q <= 1'b0;
            deny_q  <= 1'b0;
        end else begin
            grant_q <= 1'b0;
            deny_q  <= 1'b0;
            if (cs_n_i || ev.stop) begin
                st <= ST_IDLE;
            end else if (ev.start) begin
                if (st != ST_POLL) begin
                    st <= ST_CMD;
                end
            end else if (byte_done) begin
                case (st)
                    ST_CMD: begin
                        if (wr_busy_i) begin
                            st <= ST_IDLE;
                        end else begin
                            st        <= ST_PW;
                            cmd_q.wr  <= byte_val[CMD_WR_BIT];
                            cmd_q.idx <= byte_val[IDX_W-1:0];
                            pw_cnt    <= '0;
                            match_q   <= 1'b1;
                        end
                    end
                    ST_PW: begin
                        match_q <= match_q & (byte_val == pw_byte);
                        pw_cnt  <= pw_cnt + 1'b1;
                        if (pw_cnt == PW_LAST) begin
                            st <= ST_POLL;
                        end
                    end
                    ST_POLL: begin
                        if (!match_q) begin
                            st     <= ST_IDLE;
                            deny_q <= 1'b1;
                        end else if (!wr_busy_i) begin
                            st      <= ST_OPEN;
                            grant_q <= 1'b1;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    assign sda_o    = 1'b0;
    assign sda_oe_o = ack_drv & ~cs_n_i;
    assign sel_o    = cmd_q.idx;
    assign dir_wr_o = cmd_q.wr;
    assign grant_o  = grant_q;
    assign deny_o   = deny_q;
    assign open_o   = (st == ST_OPEN);

endmodule

// File: rtl/pwf_chk.sv
module pwf_chk
    import pwf_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic cs_n_i,
    input logic wr_busy_i,
    input logic sda_oe_o,
    input logic open_o,
    input logic grant_o,
    input logic deny_o,
    input logic stop_det,
    input logic byte_done,
    input st_e  st
);

    a_r10_deselect_closes: assert property (@(posedge clk) disable iff (rst)
        cs_n_i |=> !open_o);

    a_r6_grant_opens: assert property (@(posedge clk) disable iff (rst)
        grant_o |-> open_o);

    a_r6_open_needs_grant: assert property (@(posedge clk) disable iff (rst)
        $rose(open_o) |-> grant_o);

    a_r6_single_verdict: assert property (@(posedge clk) disable iff (rst)
        $onehot0({grant_o, deny_o}));

    a_r5_deny_standby: assert property (@(posedge clk) disable iff (rst)
        deny_o |-> (!open_o && !sda_oe_o));

    a_r7_busy_cmd_nack: assert property (@(posedge clk) disable iff (rst)
        (byte_done && st == ST_CMD && wr_busy_i) |=> !sda_oe_o);

    a_r9_stop_standby: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (st == ST_IDLE));

endmodule

bind pwf_front pwf_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n_i    (cs_n_i),
    .wr_busy_i (wr_busy_i),
    .sda_oe_o  (sda_oe_o),
    .open_o    (open_o),
    .grant_o   (grant_o),
    .deny_o    (deny_o),
    .stop_det  (stop_det),
    .byte_done (byte_done),
    .st        (st)
);

// File: tb/pwf_front_test.sv
`timescale 1ns/1ps
module pwf_front_test;
    import pwf_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cs_n = 1'b1;
    logic             scl = 1'b1;
    logic             m_sda = 1'b1;
    logic             line;
    logic             sda_o, sda_oe;
    logic             busy = 1'b0;
    logic             ld = 1'b0;
    logic [IDX_W-1:0] ld_idx = '0;
    logic [PW_W-1:0]  ld_val = '0;
    logic [IDX_W-1:0] sel;
    logic             dir_wr, grant, deny, open_w;
    int               checks = 0;
    int               errors = 0;
    int               gcnt = 0;
    int               dcnt = 0;
    bit               done = 0;

    localparam logic [63:0] KEY = 64'h0123456789ABCDEF;

    always #2.5 clk = ~clk;

    assign line = sda_oe ? sda_o : m_sda;

    pwf_front uut (
        .clk(clk), .rst(rst), .cs_n_i(cs_n), .scl_i(scl), .sda_i(line),
        .sda_o(sda_o), .sda_oe_o(sda_oe), .wr_busy_i(busy),
        .pw_load_i(ld), .pw_load_idx_i(ld_idx), .pw_load_val_i(ld_val),
        .sel_o(sel), .dir_wr_o(dir_wr), .grant_o(grant), .deny_o(deny), .open_o(open_w)
    );

    always @(negedge clk) begin
        if (grant) gcnt++;
        if (deny)  dcnt++;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(2);
        scl = 1'b1;   tick(3);
        m_sda = 1'b0; tick(3);
        scl = 1'b0;   tick(2);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(2);
        scl = 1'b1;   tick(3);
        m_sda = 1'b1; tick(3);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ackd);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(2);
            scl = 1'b1;   tick(4);
            scl = 1'b0;   tick(2);
        end
        m_sda = 1'b1; tick(2);
        scl = 1'b1;   tick(2);
        ackd = (line == 1'b0);
        tick(2);
        scl = 1'b0;   tick(2);
    endtask

    task automatic send_pw(input logic [63:0] pw, output int acks);
        logic a;
        acks = 0;
        for (int k = 7; k >= 0; k--) begin
            send_byte(pw[k*8 +: 8], a);
            if (a) acks++;
        end
    endtask

    task automatic txn(input logic [7:0] cmd, input logic [63:0] pw,
                       output logic cmd_ack, output int pw_acks, output logic poll_ack);
        logic a;
        bus_start();
        send_byte(cmd, a);
        cmd_ack = a;
        send_pw(pw, pw_acks);
        bus_start();
        send_byte(8'hA5, poll_ack);
    endtask

    task automatic t_reset();
        chk("R1 sda_oe after reset", sda_oe, 0);
        chk("R1 open after reset", open_w, 0);
        chk("R1 no verdict after reset", gcnt + dcnt, 0);
    endtask

    task automatic t_zero_pw();
        logic ca, pa; int n; int g0;
        cs_n = 1'b0; tick(4);
        g0 = gcnt;
        txn(8'h02, 64'h0, ca, n, pa);
        chk("R3 command ack", ca, 1);
        chk("R3 password byte acks", n, 8);
        chk("R1 zero password poll ack", pa, 1);
        chk("R6 grant pulse", gcnt - g0, 1);
        chk("R6 open level", open_w, 1);
        chk("R2 sel from command", sel, 2);
        chk("R2 read direction", dir_wr, 0);
        bus_stop(); tick(2);
        chk("R9 stop closes window", open_w, 0);
        txn(8'h7E, 64'h0, ca, n, pa);
        chk("R2 ignored command bits", pa, 1);
        chk("R2 sel with ignored bits", sel, 2);
        scl = 1'b0;
        bus_stop(); tick(2);
    endtask

    task automatic t_load();
        logic ca, pa; int n; int g0, d0;
        @(negedge clk); ld = 1'b1; ld_idx = 2'd1; ld_val = KEY;
        @(negedge clk); ld = 1'b0;
        g0 = gcnt; d0 = dcnt;
        txn(8'h81, KEY, ca, n, pa);
        chk("R11 loaded password accepted", pa, 1);
        chk("R11 grant on loaded password", gcnt - g0, 1);
        chk("R6 write direction", dir_wr, 1);
        chk("R6 sel index 1", sel, 1);
        bus_stop(); tick(2);
        txn(8'h80, KEY, ca, n, pa);
        chk("R4 key offered to other index nacked", pa, 0);
        chk("R4 deny for other index", dcnt - d0, 1);
        bus_stop(); tick(2);
        txn(8'h81, 64'h0, ca, n, pa);
        chk("R11 old zero value replaced", pa, 0);
        bus_stop(); tick(2);
    endtask

    task automatic t_mismatch();
        logic ca, pa; int n; int d0;
        d0 = dcnt;
        txn(8'h01, KEY ^ 64'h1, ca, n, pa);
        chk("R5 all bytes acked on mismatch", n, 8);
        chk("R5 poll nacked", pa, 0);
        chk("R5 deny pulse", dcnt - d0, 1);
        chk("R5 window stays closed", open_w, 0);
        bus_stop(); tick(2);
        txn(8'h01, 64'hEFCDAB8967452301, ca, n, pa);
        chk("R4 reversed byte order refused", pa, 0);
        bus_stop(); tick(2);
    endtask

    task automatic t_busy_cmd();
        logic a;
        busy = 1'b1;
        bus_start();
        send_byte(8'h02, a);
        chk("R7 command nacked while busy", a, 0);
        send_byte(8'h00, a);
        chk("R7 standby after busy command", a, 0);
        busy = 1'b0;
        bus_stop(); tick(2);
    endtask

    task automatic t_busy_poll();
        logic a; int n; int g0;
        g0 = gcnt;
        bus_start();
        send_byte(8'h81, a);
        send_pw(KEY, n);
        busy = 1'b1;
        bus_start();
        send_byte(8'h00, a);
        chk("R8 poll nacked while busy", a, 0);
        chk("R8 no grant while busy", gcnt - g0, 0);
        busy = 1'b0;
        bus_start();
        send_byte(8'h00, a);
        chk("R8 later poll acked", a, 1);
        chk("R8 later grant", gcnt - g0, 1);
        bus_stop(); tick(2);
    endtask

    task automatic t_stop_cancel();
        logic a; int g0;
        g0 = gcnt;
        bus_start();
        send_byte(8'h81, a);
        for (int k = 7; k >= 4; k--) send_byte(KEY[k*8 +: 8], a);
        bus_stop(); tick(2);
        chk("R9 stop mid password closed", open_w, 0);
        bus_start();
        for (int k = 3; k >= 0; k--) send_byte(KEY[k*8 +: 8], a);
        bus_start();
        send_byte(8'h00, a);
        chk("R9 progress dropped no grant", gcnt - g0, 0);
        chk("R9 window closed", open_w, 0);
        bus_stop(); tick(2);
    endtask

    task automatic t_deselect();
        logic ca, pa, a; int n; int g0;
        txn(8'h03, 64'h0, ca, n, pa);
        chk("R6 granted before deselect", open_w, 1);
        cs_n = 1'b1; tick(2);
        chk("R10 deselect closes window", open_w, 0);
        g0 = gcnt;
        bus_start();
        send_byte(8'h03, a);
        chk("R10 no ack while deselected", a, 0);
        send_pw(64'h0, n);
        chk("R10 password ignored while deselected", n, 0);
        chk("R10 no grant while deselected", gcnt - g0, 0);
        scl = 1'b0; m_sda = 1'b1; tick(2);
    endtask

    initial begin
        tick(4);
        rst = 1'b0;
        tick(2);
        t_reset();
        t_zero_pw();
        t_load();
        t_mismatch();
        t_busy_cmd();
        t_busy_poll();
        t_stop_cancel();
        t_deselect();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule